// File: doc/BRIEF.md
# USB Host Functional State Controller

This block keeps the operating-mode control register of a USB host controller and runs the host functional state machine. The machine has four states: reset, resume, operational and suspend. Software selects a state by writing the register. Two hardware events also change the state. A hardware reset puts the block in the reset state. A software-reset strobe puts it in the suspend state. While the block is in suspend, a resume detected downstream moves it to resume without any software write. Each state drives its own downstream signalling indications. The reset state also holds the root hub in reset.

While the state is operational, a frame timer counts `CYCLES_PER_MS` clock cycles for each 1 ms frame and raises a one-cycle start-of-frame pulse at the end of each frame. Every pulse advances a 16-bit frame number. The bulk and control list enables are copied into frame-latched outputs only on that pulse. List-processing logic downstream therefore sees enables that stay fixed for a whole frame. A register read returns the live hardware state and a sticky flag that records an automatic resume.

Top module: `usbh_fstate_ctrl`

## Requirements
- R1: After hardware reset the state is reset (00), every control field reads 0, `rd_data` is 0, the frame number is 0, both latched enables are 0 and no start-of-frame pulse is raised.
- R2: A write stores wakeup-connected at bit 9, interrupt routing at bit 8, functional state at bits 7:6 (00 reset, 01 resume, 10 operational, 11 suspend), bulk enable at bit 5 and control enable at bit 4. A read returns them at the same positions and returns every other bit except bit 16 as 0.
- R3: A software-reset strobe sets the state to suspend (11), clears the other control fields and the sticky flag, sets the frame number to 0 and clears the latched enables.
- R4: In suspend, `rsm_det` high moves the state to resume (01) at the next edge and sets the sticky resume flag, read at bit 16. In any other state `rsm_det` has no effect.
- R5: Writing 1 to bit 16 clears the sticky flag. Writing 0 to bit 16 leaves it set.
- R6: `hub_rst` and `dn_reset` are high exactly while the state is reset. `dn_resume` is high exactly while the state is resume.
- R7: After each entry to operational, the first start-of-frame pulse is high in the `CYCLES_PER_MS`-th cycle in that state. Later pulses come every `CYCLES_PER_MS` cycles. No pulse is raised outside operational, and leaving and re-entering operational restarts the frame timer.
- R8: The frame number rises by one at the edge that ends each start-of-frame cycle, wraps from 0xFFFF to 0, and otherwise holds.
- R9: The latched bulk and control enables take the register values that are current in a start-of-frame cycle, and change at no other time. A write made during the frame, or in the start-of-frame cycle itself, is seen only after the next start-of-frame.
- R10: `irq_out` follows `irq_in` when the interrupt-routing bit is 0, and is held low when that bit is 1.
- R11: The wakeup-connected bit reads back as written and changes no output other than `rd_data`.
- R12: Hardware reset takes priority over the software-reset strobe. The software-reset strobe takes priority over a register write and over an automatic resume in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software-reset strobe |
| wr_en | input | 1 | Control register write enable |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read value (live state and sticky flag) |
| rsm_det | input | 1 | Downstream resume detected |
| irq_in | input | 1 | Interrupt request from the host controller core |
| irq_out | output | 1 | Interrupt forwarded to the system interrupt controller |
| fstate | output | 2 | Current functional state |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| frame_num | output | 16 | Frame number |
| bulk_en_frm | output | 1 | Bulk list enable latched at the last start-of-frame |
| ctrl_en_frm | output | 1 | Control list enable latched at the last start-of-frame |
| hub_rst | output | 1 | Root hub reset |
| dn_reset | output | 1 | Downstream reset signalling request |
| dn_resume | output | 1 | Downstream resume signalling request |

## Verification
The bench goes after the cycle on which each start-of-frame pulse lands, both after a first entry and after a re-entry from resume. A timer that kept running outside operational, or that started at 1, would put the pulse a cycle early or late. It writes the list enables in the middle of a frame and in the start-of-frame cycle itself, where a latch that took the new write value would expose a half-applied change one frame too soon. It drives a full pass of the frame number through the 0xFFFF wrap, and it applies hardware reset, software reset, writes and resume detects in the same cycle. A wrong priority there would leave the block in resume or reset instead of suspend.

// File: rtl/usbh_fs_pkg.sv
package usbh_fs_pkg;

    typedef enum logic [1:0] {
        FS_RESET   = 2'b00,
        FS_RESUME  = 2'b01,
        FS_OPER    = 2'b10,
        FS_SUSPEND = 2'b11
    } fstate_e;

    // Bit positions inside the control register
    localparam int POS_CLE  = 4;
    localparam int POS_BLE  = 5;
    localparam int POS_FS   = 6;
    localparam int POS_IR   = 8;
    localparam int POS_RWC  = 9;
    localparam int POS_SEEN = 16;

    typedef struct packed {
        logic    rwc;
        logic    ir;
        fstate_e fs;
        logic    ble;
        logic    cle;
    } ctrl_t;

    localparam ctrl_t CTRL_HW_RST = '{rwc: 1'b0, ir: 1'b0, fs: FS_RESET,   ble: 1'b0, cle: 1'b0};
    localparam ctrl_t CTRL_SW_RST = '{rwc: 1'b0, ir: 1'b0, fs: FS_SUSPEND, ble: 1'b0, cle: 1'b0};

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.rwc = w[POS_RWC];
        c.ir  = w[POS_IR];
        c.fs  = fstate_e'(w[POS_FS +: 2]);
        c.ble = w[POS_BLE];
        c.cle = w[POS_CLE];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c, input logic seen);
        logic [31:0] w;
        w              = '0;
        w[POS_RWC]     = c.rwc;
        w[POS_IR]      = c.ir;
        w[POS_FS +: 2] = c.fs;
        w[POS_BLE]     = c.ble;
        w[POS_CLE]     = c.cle;
        w[POS_SEEN]    = seen;
        return w;
    endfunction

endpackage

// File: rtl/usbh_fs_ctrlreg.sv
module usbh_fs_ctrlreg
    import usbh_fs_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rsm_det,
    output ctrl_t            ctrl,
    output logic             seen
);

    ctrl_t ctrl_nxt;
    logic  seen_nxt;
    logic  auto_rsm;

    assign auto_rsm = (ctrl.fs == FS_SUSPEND) && rsm_det;

    always_comb begin
        ctrl_nxt = ctrl;
        seen_nxt = seen;
        if (wr_en) begin
            ctrl_nxt = ctrl_from_word(32'(wr_data));
            if (wr_data[POS_SEEN]) seen_nxt = 1'b0;
        end
        if (auto_rsm) begin
            ctrl_nxt.fs = FS_RESUME;
            seen_nxt    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_HW_RST;
            seen <= 1'b0;
        end else if (sw_rst) begin
            ctrl <= CTRL_SW_RST;
            seen <= 1'b0;
        end else begin
            ctrl <= ctrl_nxt;
            seen <= seen_nxt;
        end
    end

endmodule

// File: rtl/usbh_fs_frame.sv
module usbh_fs_frame #(
    parameter int CYCLES_PER_MS = 48000,
    parameter int FRAME_W       = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               run,
    input  logic               ble,
    input  logic               cle,
    output logic               sof,
    output logic [FRAME_W-1:0] frame_num,
    output logic               ble_frm,
    output logic               cle_frm
);

    localparam int TW = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
    localparam logic [TW-1:0] LAST = TW'(CYCLES_PER_MS - 1);

    logic [TW-1:0] tmr;
    logic          at_end;

    assign at_end = (tmr == LAST);
    assign sof    = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tmr       <= '0;
            frame_num <= '0;
            ble_frm   <= 1'b0;
            cle_frm   <= 1'b0;
        end else begin
            if (!run || at_end) tmr <= '0;
            else                tmr <= tmr + 1'b1;
            if (sof) begin
                frame_num <= frame_num + 1'b1;
                ble_frm   <= ble;
                cle_frm   <= cle;
            end
        end
    end

endmodule

// File: rtl/usbh_fs_sigdec.sv
module usbh_fs_sigdec
    import usbh_fs_pkg::*;
(
    input  fstate_e st,
    input  logic    ir,
    input  logic    irq_in,
    output logic    hub_rst,
    output logic    dn_reset,
    output logic    dn_resume,
    output logic    irq_out
);

    always_comb begin
        hub_rst   = 1'b0;
        dn_reset  = 1'b0;
        dn_resume = 1'b0;
        unique case (st)
            FS_RESET: begin
                hub_rst  = 1'b1;
                dn_reset = 1'b1;
            end
            FS_RESUME:  dn_resume = 1'b1;
            FS_OPER:    ;
            FS_SUSPEND: ;
            default:    ;
        endcase
    end

    assign irq_out = irq_in && !ir;

endmodule

// File: rtl/usbh_fstate_ctrl.sv
module usbh_fstate_ctrl
    import usbh_fs_pkg::*;
#(
    parameter int CYCLES_PER_MS = 48000,
    parameter int REG_W         = 32,
    parameter int FRAME_W       = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               rsm_det,
    input  logic               irq_in,
    output logic               irq_out,
    output logic [1:0]         fstate,
    output logic               sof_pulse,
    output logic [FRAME_W-1:0] frame_num,
    output logic               bulk_en_frm,
    output logic               ctrl_en_frm,
    output logic               hub_rst,
    output logic               dn_reset,
    output logic               dn_resume
);

    ctrl_t ctrl;
    logic  seen;

    usbh_fs_ctrlreg #(.REG_W(REG_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .sw_rst  (sw_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rsm_det (rsm_det),
        .ctrl    (ctrl),
        .seen    (seen)
    );

    usbh_fs_frame #(
        .CYCLES_PER_MS (CYCLES_PER_MS),
        .FRAME_W       (FRAME_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .clr       (sw_rst),
        .run       (ctrl.fs == FS_OPER),
        .ble       (ctrl.ble),
        .cle       (ctrl.cle),
        .sof       (sof_pulse),
        .frame_num (frame_num),
        .ble_frm   (bulk_en_frm),
        .cle_frm   (ctrl_en_frm)
    );

    usbh_fs_sigdec u_sig (
        .st        (ctrl.fs),
        .ir        (ctrl.ir),
        .irq_in    (irq_in),
        .hub_rst   (hub_rst),
        .dn_reset  (dn_reset),
        .dn_resume (dn_resume),
        .irq_out   (irq_out)
    );

    assign fstate  = ctrl.fs;
    assign rd_data = REG_W'(ctrl_to_word(ctrl, seen));

endmodule

// File: rtl/usbh_fstate_ctrl_chk.sv
module usbh_fstate_ctrl_chk #(
    parameter int CYCLES_PER_MS = 48000,
    parameter int REG_W         = 32,
    parameter int FRAME_W       = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               sw_rst,
    input logic               rsm_det,
    input logic               irq_in,
    input logic               irq_out,
    input logic [REG_W-1:0]   rd_data,
    input logic [1:0]         fstate,
    input logic               sof_pulse,
    input logic [FRAME_W-1:0] frame_num,
    input logic               bulk_en_frm,
    input logic               ctrl_en_frm
);

    localparam int GW = $clog2(CYCLES_PER_MS + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(CYCLES_PER_MS - 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || fstate != 2'b10 || sof_pulse) gap <= '0;
        else                                      gap <= gap + 1'b1;
    end

    // R7
    sof_only_oper_chk: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> fstate == 2'b10);

    // R7
    sof_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> gap == GAP_LAST);

    // R7
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fstate == 2'b10 |-> gap <= GAP_LAST);

    // R8
    frame_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && !sw_rst) |=> frame_num == FRAME_W'($past(frame_num) + 1'b1));

    // R8
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sof_pulse && !sw_rst) |=> $stable(frame_num));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sof_pulse && !sw_rst) |=> ($stable(bulk_en_frm) && $stable(ctrl_en_frm)));

    // R4
    auto_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (fstate == 2'b11 && rsm_det && !sw_rst) |=> (fstate == 2'b01 && rd_data[16]));

    // R3
    sw_reset_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (fstate == 2'b11 && frame_num == '0));

    // R10
    irq_route_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (irq_in && !rd_data[8]));

endmodule

bind usbh_fstate_ctrl usbh_fstate_ctrl_chk #(
    .CYCLES_PER_MS (CYCLES_PER_MS),
    .REG_W         (REG_W),
    .FRAME_W       (FRAME_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sw_rst      (sw_rst),
    .rsm_det     (rsm_det),
    .irq_in      (irq_in),
    .irq_out     (irq_out),
    .rd_data     (rd_data),
    .fstate      (fstate),
    .sof_pulse   (sof_pulse),
    .frame_num   (frame_num),
    .bulk_en_frm (bulk_en_frm),
    .ctrl_en_frm (ctrl_en_frm)
);

// File: tb/sim_usbh_fstate_ctrl.sv
module sim_usbh_fstate_ctrl;

    localparam int CPM = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rsm_det = 1'b0;
    logic        irq_in = 1'b0;
    logic        irq_out;
    logic [1:0]  fstate;
    logic        sof_pulse;
    logic [15:0] frame_num;
    logic        bulk_en_frm;
    logic        ctrl_en_frm;
    logic        hub_rst;
    logic        dn_reset;
    logic        dn_resume;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    usbh_fstate_ctrl #(.CYCLES_PER_MS(CPM)) u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rsm_det(rsm_det), .irq_in(irq_in), .irq_out(irq_out),
        .fstate(fstate), .sof_pulse(sof_pulse), .frame_num(frame_num),
        .bulk_en_frm(bulk_en_frm), .ctrl_en_frm(ctrl_en_frm),
        .hub_rst(hub_rst), .dn_reset(dn_reset), .dn_resume(dn_resume)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        chk("R1 state", 32'(fstate), 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 frame/latch/sof", {13'h0, sof_pulse, bulk_en_frm, ctrl_en_frm, frame_num}, 32'h0);
        // R6: reset state drives hub and downstream reset
        chk("R6 reset signals", {29'h0, hub_rst, dn_reset, dn_resume}, 32'h6);

        // R12: hardware reset over software reset
        wr(32'h0000_00C0);
        rst = 1'b1; sw_rst = 1'b1;
        tick();
        rst = 1'b0; sw_rst = 1'b0;
        chk("R12 hw over sw", 32'(fstate), 32'h0);

        // R2: field positions, other bits read 0
        wr(32'hFFFF_FFFF);
        chk("R2 readback all", rd_data, 32'h0000_03F0);
        chk("R6 suspend signals", {29'h0, hub_rst, dn_reset, dn_resume}, 32'h0);

        // R10: interrupt routing
        irq_in = 1'b1;
        tick();
        chk("R10 routed away", 32'(irq_out), 32'h0);
        wr(32'h0000_00C0);
        chk("R10 forwarded", 32'(irq_out), 32'h1);
        irq_in = 1'b0;
        tick();
        chk("R10 idle", 32'(irq_out), 32'h0);

        // R4: automatic resume from suspend
        rsm_det = 1'b1;
        tick();
        rsm_det = 1'b0;
        chk("R4 auto resume", rd_data, 32'h0001_0040);
        chk("R6 resume signals", {29'h0, hub_rst, dn_reset, dn_resume}, 32'h1);
        rsm_det = 1'b1;
        tick();
        rsm_det = 1'b0;
        chk("R4 no effect in resume", 32'(fstate), 32'h1);
        // R5: sticky flag
        wr(32'h0000_0040);
        chk("R5 write 0 keeps", rd_data, 32'h0001_0040);
        wr(32'h0001_0040);
        chk("R5 write 1 clears", rd_data, 32'h0000_0040);
        wr(32'h0000_0000);
        chk("R6 reset via write", {29'h0, hub_rst, dn_reset, dn_resume}, 32'h6);
        rsm_det = 1'b1;
        tick();
        rsm_det = 1'b0;
        chk("R4 no effect in reset", rd_data, 32'h0);

        // R12: software reset over automatic resume
        wr(32'h0000_00C0);
        sw_rst = 1'b1; rsm_det = 1'b1;
        tick();
        sw_rst = 1'b0; rsm_det = 1'b0;
        chk("R12 sw over resume", rd_data, 32'h0000_00C0);

        // R3 and R12: software reset from operational, with a write in the same cycle
        wr(32'h0000_03B0);
        tick();
        tick();
        chk("R9 latched on sof", {30'h0, bulk_en_frm, ctrl_en_frm}, 32'h3);
        sw_rst = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0080;
        tick();
        sw_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R3 R12 sw reset fields", rd_data, 32'h0000_00C0);
        chk("R3 frame and latches", {14'h0, bulk_en_frm, ctrl_en_frm, frame_num}, 32'h0);

        // R7 / R9: first entry, latching cadence (CPM = 2)
        wr(32'h0000_0090);
        chk("R7 entry cycle no sof", 32'(sof_pulse), 32'h0);
        tick();
        chk("R7 first sof", 32'(sof_pulse), 32'h1);
        chk("R9 not yet latched", 32'(ctrl_en_frm), 32'h0);
        tick();
        chk("R9 control latched", {15'h0, ctrl_en_frm, frame_num}, 32'h1_0001);
        wr(32'h0000_00B0);
        chk("R7 second sof", 32'(sof_pulse), 32'h1);
        chk("R9 mid-frame write hidden", {30'h0, rd_data[5], bulk_en_frm}, 32'h2);
        tick();
        chk("R9 bulk latched", {15'h0, bulk_en_frm, frame_num}, 32'h1_0002);
        tick();
        wr(32'h0000_0080);
        chk("R9 sof-cycle write hidden", {30'h0, bulk_en_frm, ctrl_en_frm}, 32'h3);
        chk("R8 frame 3", 32'(frame_num), 32'h3);
        tick();
        tick();
        chk("R9 cleared next frame", {30'h0, bulk_en_frm, ctrl_en_frm}, 32'h0);

        // R11: wakeup-connected bit has no effect
        wr(32'h0000_0280);
        chk("R11 sof cadence kept", 32'(sof_pulse), 32'h1);
        chk("R11 readback", rd_data, 32'h0000_0280);
        irq_in = 1'b1;
        tick();
        chk("R11 irq unaffected", {30'h0, irq_out, sof_pulse}, 32'h2);
        irq_in = 1'b0;

        // R7: re-entry restarts the timer
        wr(32'h0000_0040);
        chk("R7 no sof in resume", 32'(sof_pulse), 32'h0);
        tick();
        chk("R7 R8 idle in resume", {15'h0, sof_pulse, frame_num}, 32'h5);
        wr(32'h0000_0080);
        chk("R7 re-entry no sof", 32'(sof_pulse), 32'h0);
        tick();
        chk("R7 re-entry sof", 32'(sof_pulse), 32'h1);

        // R8: full frame number sweep through the wrap
        sw_rst = 1'b1;
        tick();
        sw_rst = 1'b0;
        wr(32'h0000_0080);
        for (int i = 0; i <= 65536; i++) begin
            chk("R8 frame sweep", {15'h0, sof_pulse, frame_num}, 32'(i % 65536));
            tick();
            chk("R7 sweep sof", 32'(sof_pulse), 32'h1);
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule